// File: doc/BRIEF.md
# Write-Completion Status Reporter

This block sits between the read port of a self-timed non-volatile array and the host. While a programming cycle is in progress, the array contents cannot be read. During that time the block replaces each returned byte with end-of-write status, so software can tell when programming has finished. It offers two status methods at once. The top bit is the inverse of the top bit of the byte most recently written. The next bit down changes value on every read. The remaining low bits echo the last written byte. When the busy flag is low, the array data passes through untouched.

A read happens when either the output-enable read strobe or the chip-enable read strobe is high for a cycle. The returned byte is registered on that clock edge and appears on the output one cycle after the strobe. The output holds its value until the next read. The busy flag is sampled in the same cycle as the strobe, so a read issued in the first cycle after busy drops already returns array data.

Top module: `wrpoll_status`

## Requirements
- R1: After reset, host_rd_data is all zeros, and the first busy read after reset returns bit 6 as 0.
- R2: A read taken while prog_busy is 1 returns, in the next cycle, bit 7 equal to the inverse of bit 7 of last_wr_byte.
- R3: Consecutive reads taken while prog_busy is 1 return bit 6 with alternating values, each the inverse of the previous busy read's bit 6.
- R4: A read taken while prog_busy is 1 returns bits 5 to 0 equal to bits 5 to 0 of last_wr_byte, whatever array_rd_data holds.
- R5: A read taken while prog_busy is 0 returns all eight bits of array_rd_data, in the next cycle.
- R6: Reads taken while prog_busy is 0 leave the bit-6 toggle unchanged. The first busy read after an idle stretch returns the inverse of the bit 6 from the last busy read before it.
- R7: A read is triggered by oe_rd, by ce_rd, or by both together. When both are high in the same cycle, that counts as a single read and the toggle advances only once.
- R8: In a cycle with neither strobe high, host_rd_data keeps its value, even if the other inputs change.
- R9: A read issued in the first cycle in which prog_busy is 0, right after a busy stretch, returns array_rd_data with no extra recovery delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| prog_busy | input | 1 | High while the array is programming |
| oe_rd | input | 1 | One-cycle read strobe derived from output enable |
| ce_rd | input | 1 | One-cycle read strobe derived from chip enable |
| last_wr_byte | input | 8 | Byte most recently loaded for programming |
| array_rd_data | input | 8 | Data read from the array at the current address |
| host_rd_data | output | 8 | Byte returned to the host, registered on a read |

## Verification
The checker assumes that prog_busy, last_wr_byte and array_rd_data are steady in the cycle a read strobe is sampled. It also assumes that each strobe pulse stands for exactly one host read, so toggle alternation can be tied to strobe cycles. The stimulus changes every input only on the falling clock edge and keeps each strobe high for one cycle. It covers reads from each strobe source alone and from both together, idle reads placed between busy reads, and a read in the very cycle busy drops.

// File: rtl/wrpoll_pkg.sv
package wrpoll_pkg;
  localparam int unsigned WRP_DATA_W = 8;
  typedef enum logic [0:0] {SRC_ARRAY = 1'b0, SRC_STATUS = 1'b1} wrp_src_e;
endpackage

// File: rtl/wrp_strobe_merge.sv
module wrp_strobe_merge (
  input  logic oe_rd,
  input  logic ce_rd,
  input  logic prog_busy,
  output logic rd_any,
  output logic rd_busy
);
  always_comb begin
    rd_any  = oe_rd | ce_rd;
    rd_busy = rd_any & prog_busy;
  end
endmodule

// File: rtl/wrp_toggle.sv
module wrp_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_en,
  output logic tog_q
);
  logic tog_d;

  always_comb begin
    tog_d = tog_q;
    if (adv_en) tog_d = ~tog_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= tog_d;
  end
endmodule

// File: rtl/wrp_out_sel.sv
module wrp_out_sel
  import wrpoll_pkg::*;
#(
  parameter int unsigned DATA_W = WRP_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  wrp_src_e          src,
  input  logic              tog_val,
  input  logic [DATA_W-1:0] last_wr,
  input  logic [DATA_W-1:0] arr_data,
  output logic [DATA_W-1:0] out_q
);
  localparam int unsigned POLL_IDX = DATA_W - 1;
  localparam int unsigned TOG_IDX  = DATA_W - 2;

  logic [DATA_W-1:0] status_w;
  logic [DATA_W-1:0] out_d;

  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_bit
      if (gi == POLL_IDX) begin : g_poll
        assign status_w[gi] = ~last_wr[gi];
      end else if (gi == TOG_IDX) begin : g_tog
        assign status_w[gi] = tog_val;
      end else begin : g_echo
        assign status_w[gi] = last_wr[gi];
      end
    end
  endgenerate

  always_comb begin
    out_d = out_q;
    if (load_en) out_d = (src == SRC_STATUS) ? status_w : arr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end
endmodule

// File: rtl/wrpoll_status.sv
module wrpoll_status
  import wrpoll_pkg::*;
#(
  parameter int unsigned DATA_W = WRP_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_busy,
  input  logic              oe_rd,
  input  logic              ce_rd,
  input  logic [DATA_W-1:0] last_wr_byte,
  input  logic [DATA_W-1:0] array_rd_data,
  output logic [DATA_W-1:0] host_rd_data
);
  logic     rd_any;
  logic     rd_busy;
  logic     tog_q;
  wrp_src_e src_sel;

  assign src_sel = prog_busy ? SRC_STATUS : SRC_ARRAY;

  wrp_strobe_merge u_strobe (
    .oe_rd     (oe_rd),
    .ce_rd     (ce_rd),
    .prog_busy (prog_busy),
    .rd_any    (rd_any),
    .rd_busy   (rd_busy)
  );

  wrp_toggle u_tog (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv_en (rd_busy),
    .tog_q  (tog_q)
  );

  wrp_out_sel #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (rd_any),
    .src      (src_sel),
    .tog_val  (tog_q),
    .last_wr  (last_wr_byte),
    .arr_data (array_rd_data),
    .out_q    (host_rd_data)
  );
endmodule

// File: rtl/wrpoll_status_chk.sv
module wrpoll_status_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              prog_busy,
  input logic              oe_rd,
  input logic              ce_rd,
  input logic [DATA_W-1:0] last_wr_byte,
  input logic [DATA_W-1:0] array_rd_data,
  input logic [DATA_W-1:0] host_rd_data
);
  localparam int unsigned P = DATA_W - 1;
  localparam int unsigned T = DATA_W - 2;

  logic rd;
  logic pend_q;
  logic have_q;
  logic prev6_q;

  assign rd = oe_rd | ce_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      have_q  <= 1'b0;
      prev6_q <= 1'b1;
    end else begin
      pend_q <= rd & prog_busy;
      if (pend_q) begin
        have_q  <= 1'b1;
        prev6_q <= host_rd_data[T];
      end
    end
  end

  // R2
  busy_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && prog_busy) |=> host_rd_data[P] == ~$past(last_wr_byte[P]));

  // R4
  busy_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && prog_busy) |=> host_rd_data[T-1:0] == $past(last_wr_byte[T-1:0]));

  // R3
  busy_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && have_q) |-> host_rd_data[T] != prev6_q);

  // R1
  first_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !have_q) |-> host_rd_data[T] == 1'b0);

  // R5
  idle_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !prog_busy) |=> host_rd_data == $past(array_rd_data));

  // R8
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(host_rd_data));
endmodule

bind wrpoll_status wrpoll_status_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .prog_busy     (prog_busy),
  .oe_rd         (oe_rd),
  .ce_rd         (ce_rd),
  .last_wr_byte  (last_wr_byte),
  .array_rd_data (array_rd_data),
  .host_rd_data  (host_rd_data)
);

// File: tb/sim_wrpoll_status.sv
module sim_wrpoll_status;
  logic       clk;
  logic       rst_n;
  logic       prog_busy;
  logic       oe_rd;
  logic       ce_rd;
  logic [7:0] last_wr_byte;
  logic [7:0] array_rd_data;
  logic [7:0] host_rd_data;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  wrpoll_status u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .prog_busy     (prog_busy),
    .oe_rd         (oe_rd),
    .ce_rd         (ce_rd),
    .last_wr_byte  (last_wr_byte),
    .array_rd_data (array_rd_data),
    .host_rd_data  (host_rd_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {busy, oe, ce, last, array, expected}; toggle starts at 0 after reset
  localparam int NV = 10;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 8'hA5, 8'h3C, 8'h25}, // R2 R4 toggle 0
    {1'b1, 1'b0, 1'b1, 8'hA5, 8'h3C, 8'h65}, // R3 R7 toggle 1 via ce
    {1'b1, 1'b1, 1'b1, 8'h0F, 8'h77, 8'h8F}, // R7 both strobes, toggle 0
    {1'b1, 1'b1, 1'b0, 8'h0F, 8'h77, 8'hCF}, // R7 advanced once only
    {1'b0, 1'b1, 1'b0, 8'h0F, 8'h3C, 8'h3C}, // R5 idle via oe
    {1'b0, 1'b0, 1'b1, 8'h0F, 8'hC3, 8'hC3}, // R5 idle via ce
    {1'b1, 1'b1, 1'b0, 8'hFF, 8'h00, 8'h3F}, // R6 toggle kept at 0
    {1'b0, 1'b1, 1'b1, 8'hFF, 8'h5A, 8'h5A}, // R5 idle, both strobes
    {1'b1, 1'b0, 1'b1, 8'h40, 8'h11, 8'hC0}, // R6 R3 toggle 1
    {1'b1, 1'b1, 1'b0, 8'h00, 8'hEE, 8'h80}  // R3 toggle 0
  };

  task automatic check(input logic [7:0] exp, input string tag);
    total++;
    if (host_rd_data !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, host_rd_data, exp);
    end
  endtask

  task automatic do_read(input logic b, input logic o, input logic c,
                         input logic [7:0] lw, input logic [7:0] ar,
                         input logic [7:0] exp, input string tag);
    @(negedge clk);
    prog_busy = b; oe_rd = o; ce_rd = c;
    last_wr_byte = lw; array_rd_data = ar;
    @(negedge clk);
    oe_rd = 1'b0; ce_rd = 1'b0;
    check(exp, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; prog_busy = 1'b0; oe_rd = 1'b0; ce_rd = 1'b0;
    last_wr_byte = 8'h00; array_rd_data = 8'h00;
    do_reset();
    @(negedge clk);
    check(8'h00, "R1 reset output");

    for (int i = 0; i < NV; i++) begin
      do_read(VEC[i][26], VEC[i][25], VEC[i][24], VEC[i][23:16],
              VEC[i][15:8], VEC[i][7:0], $sformatf("vector %0d", i));
    end

    // R8: inputs move, no strobe, output keeps 0x80
    @(negedge clk);
    prog_busy = 1'b0; last_wr_byte = 8'h12; array_rd_data = 8'h34;
    @(negedge clk);
    prog_busy = 1'b1; array_rd_data = 8'h99;
    @(negedge clk);
    check(8'h80, "R8 hold without strobe");

    // R9: busy still high, one busy read (toggle 1), then read on first idle cycle
    do_read(1'b1, 1'b1, 1'b0, 8'h81, 8'h22, 8'h41, "R9 last busy read");
    do_read(1'b0, 1'b1, 1'b0, 8'h81, 8'h22, 8'h22, "R9 first idle read");

    // R1: reset mid-sequence clears output and toggle
    do_reset();
    @(negedge clk);
    check(8'h00, "R1 reset output again");
    do_read(1'b1, 1'b0, 1'b1, 8'h7E, 8'h00, 8'hBE, "R1 first toggle after reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule